// File: doc/BRIEF.md
# Character LCD Parallel Bus Driver

This block turns a simple command stream into bus cycles for a character or graphic LCD controller. Each command carries a register-select bit (0 = instruction, 1 = RAM data), a direction bit (1 = read), one data byte and a valid/ready handshake. The block drives the select, direction and enable strobes and the eight data lines, and it controls the output enable of those lines. It also returns read data on a one-cycle response strobe.

Every transfer can be a single 8-bit bus cycle, or two 4-bit bus cycles on the upper four data lines. Nibble mode and busy polling are chosen per command and captured when the command is accepted. A read with select 0 returns the controller's busy flag in bit 7 and its address counter in bits 6..0. The block splits that byte into separate fields. With polling enabled, every write is followed by status reads until the busy flag reads clear, and only then is the next command taken.

All strobe timing comes from the system clock through four cycle-count parameters: select/direction setup, enable high time, hold after the enable falls, and minimum enable period. The defaults suit a 100 MHz clock. They give 20 ns setup, 230 ns enable high, 30 ns hold and a 1200 ns cycle. The 230 ns high time also covers a read access of up to 190 ns.

Top module: `lcdbus_drv`

## Requirements
- R1: Successive enable rising edges are at least SLOT cycles apart, where SLOT = max(CYCLE_CYC, SETUP_CYC+E_HIGH_CYC+HOLD_CYC). The two pulses of one nibble-mode command are exactly SLOT cycles apart.
- R2: Each enable pulse stays high for exactly E_HIGH_CYC cycles.
- R3: Select, direction, data lines and output enable stop changing at least SETUP_CYC cycles before the enable rises. They stay unchanged for at least HOLD_CYC cycles after it falls.
- R4: In 8-bit mode a write produces one enable pulse, with the whole byte on DB7..DB0 and the select bit as commanded.
- R5: In 4-bit mode a write produces two enable pulses. The first carries data bits 7..4 and the second carries bits 3..0, both on DB7..DB4, with DB3..DB0 driven to 0.
- R6: The data-line output enable is low whenever the direction strobe is high (read), and high during writes. On a read, the line value is captured in the last enable-high cycle. The byte is then returned on a single-cycle rsp_valid. In 4-bit mode the first pulse supplies bits 7..4.
- R7: A read with select 0 raises rsp_status, and it sets rsp_busy to bit 7 and rsp_addr to bits 6..0 of the byte read. A read with select 1 clears all three.
- R8: A write accepted with poll_en = 1 is followed by status reads (select 0, direction 1) until one returns bit 7 = 0, and cmd_ready stays low until then. Reads and writes accepted with poll_en = 0 add no status reads.
- R9: nibble_mode and poll_en are captured when a command is accepted. Changing them during the transfer has no effect on it.
- R10: After reset: enable 0, select 0, direction 1, data lines 0, output enable 0, cmd_ready 1, rsp_valid 0.
- R11: A command is accepted on a clock where cmd_valid and cmd_ready are both high. cmd_ready is low from that edge until the transfer (and any polling) ends, and the enable never pulses while cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when both are high |
| cmd_rs | input | 1 | 0 = instruction, 1 = RAM data |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_data | input | DATA_W | Write byte |
| nibble_mode | input | 1 | 1 = two 4-bit bus cycles |
| poll_en | input | 1 | 1 = poll busy flag after a write |
| rsp_valid | output | 1 | Read result strobe |
| rsp_data | output | DATA_W | Byte read |
| rsp_status | output | 1 | Result came from a status read |
| rsp_busy | output | 1 | Busy flag of a status read |
| rsp_addr | output | DATA_W-1 | Address counter of a status read |
| lcd_rs | output | 1 | Register-select strobe |
| lcd_rw | output | 1 | Direction strobe |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | DATA_W | Data lines, outgoing value |
| lcd_db_oe | output | 1 | Data-line output enable |
| lcd_db_in | input | DATA_W | Data lines, incoming value |

## Verification
A wrong slot counter shows as an enable pulse that is too narrow, too close to the previous one, or too soon after the strobes changed. This is visible on the very pulse it corrupts. A wrong nibble phase sends the halves in the wrong order or swaps the halves of a read byte, which shows on the second pulse of the same command or on its response. A wrong latch or poll state changes how many pulses a command produces, or when cmd_ready returns. This shows within one command's span, and the bench counts pulses per command to catch it.

// File: rtl/lcdbus_pkg.sv
`timescale 1ns/1ps
package lcdbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_POLL = 2'd2
  } ctrl_state_t;

  // Length of one bus slot: the longer of the minimum enable period
  // and the sum of its phases.
  function automatic int slot_len(input int cycle_c, input int setup_c,
                                  input int high_c, input int hold_c);
    int phases;
    phases = setup_c + high_c + hold_c;
    return (cycle_c > phases) ? cycle_c : phases;
  endfunction

endpackage

// File: rtl/lcdbus_strobe.sv
`timescale 1ns/1ps
module lcdbus_strobe #(
  parameter int SETUP_CYC  = 2,
  parameter int E_HIGH_CYC = 23,
  parameter int HOLD_CYC   = 3,
  parameter int CYCLE_CYC  = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic slot_go,
  output logic lcd_e,
  output logic slot_sample,
  output logic slot_done
);

  localparam int SLOT = lcdbus_pkg::slot_len(CYCLE_CYC, SETUP_CYC, E_HIGH_CYC, HOLD_CYC);
  localparam int CW   = $clog2(SLOT + 1);
  localparam logic [CW-1:0] WIN_LO = CW'(SETUP_CYC);
  localparam logic [CW-1:0] WIN_HI = CW'(SETUP_CYC + E_HIGH_CYC);
  localparam logic [CW-1:0] SMP_AT = CW'(SETUP_CYC + E_HIGH_CYC - 1);
  localparam logic [CW-1:0] LAST   = CW'(SLOT - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      lcd_e    <= 1'b0;
    end else if (slot_go) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      lcd_e    <= 1'b0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        lcd_e    <= 1'b0;
      end else begin
        cnt_q <= cnt_nx;
        lcd_e <= (cnt_nx >= WIN_LO) && (cnt_nx < WIN_HI);
      end
    end
  end

  assign slot_sample = active_q && (cnt_q == SMP_AT);
  assign slot_done   = active_q && (cnt_q == LAST);

endmodule

// File: rtl/lcdbus_ctrl.sv
`timescale 1ns/1ps
module lcdbus_ctrl
  import lcdbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rs,
  input  logic              cmd_rw,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              nibble_mode,
  input  logic              poll_en,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_status,
  output logic              rsp_busy,
  output logic [DATA_W-2:0] rsp_addr,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic [DATA_W-1:0] lcd_db_out,
  output logic              lcd_db_oe,
  input  logic [DATA_W-1:0] lcd_db_in,
  input  logic              slot_sample,
  input  logic              slot_done,
  output logic              slot_go
);

  localparam int HALF = DATA_W / 2;

  ctrl_state_t       state_q;
  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] rd_q;
  logic [HALF-1:0]   hi_q;
  logic              nib_q;
  logic              poll_q;
  logic              half_q;

  logic accept, first_half, more_half, start_poll, repoll;
  logic [HALF-1:0] in_top;

  function automatic logic [DATA_W-1:0] upper_lane(input logic [HALF-1:0] n);
    return {n, {HALF{1'b0}}};
  endfunction

  assign in_top     = lcd_db_in[DATA_W-1 -: HALF];
  assign cmd_ready  = (state_q == ST_IDLE);
  assign accept     = (state_q == ST_IDLE) && cmd_valid;
  assign first_half = nib_q && !half_q;

  always_comb begin
    more_half  = slot_done && first_half;
    start_poll = slot_done && (state_q == ST_XFER) && !first_half && !lcd_rw && poll_q;
    repoll     = slot_done && (state_q == ST_POLL) && !first_half && rd_q[DATA_W-1];
    slot_go    = accept || more_half || start_poll || repoll;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      byte_q     <= '0;
      rd_q       <= '0;
      hi_q       <= '0;
      nib_q      <= 1'b0;
      poll_q     <= 1'b0;
      half_q     <= 1'b0;
      lcd_rs     <= 1'b0;
      lcd_rw     <= 1'b1;
      lcd_db_out <= '0;
      lcd_db_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_status <= 1'b0;
      rsp_busy   <= 1'b0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= 1'b0;

      if (slot_sample) begin
        if (first_half) hi_q <= in_top;
        else            rd_q <= nib_q ? {hi_q, in_top} : lcd_db_in;
      end

      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            byte_q     <= cmd_data;
            nib_q      <= nibble_mode;
            poll_q     <= poll_en;
            half_q     <= 1'b0;
            lcd_rs     <= cmd_rs;
            lcd_rw     <= cmd_rw;
            lcd_db_oe  <= !cmd_rw;
            lcd_db_out <= cmd_rw ? '0 :
                          (nibble_mode ? upper_lane(cmd_data[DATA_W-1 -: HALF]) : cmd_data);
            state_q    <= ST_XFER;
          end
        end
        ST_XFER, ST_POLL: begin
          if (more_half) begin
            half_q     <= 1'b1;
            lcd_db_out <= lcd_rw ? '0 : upper_lane(byte_q[HALF-1:0]);
          end else if (slot_done) begin
            if (state_q == ST_XFER && lcd_rw) begin
              rsp_valid  <= 1'b1;
              rsp_data   <= rd_q;
              rsp_status <= !lcd_rs;
              rsp_busy   <= !lcd_rs && rd_q[DATA_W-1];
              rsp_addr   <= lcd_rs ? '0 : rd_q[DATA_W-2:0];
            end
            if (start_poll) begin
              state_q    <= ST_POLL;
              half_q     <= 1'b0;
              lcd_rs     <= 1'b0;
              lcd_rw     <= 1'b1;
              lcd_db_oe  <= 1'b0;
              lcd_db_out <= '0;
            end else if (repoll) begin
              half_q <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcdbus_drv.sv
`timescale 1ns/1ps
module lcdbus_drv #(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int E_HIGH_CYC = 23,
  parameter int HOLD_CYC   = 3,
  parameter int CYCLE_CYC  = 120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rs,
  input  logic              cmd_rw,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              nibble_mode,
  input  logic              poll_en,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_status,
  output logic              rsp_busy,
  output logic [DATA_W-2:0] rsp_addr,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_e,
  output logic [DATA_W-1:0] lcd_db_out,
  output logic              lcd_db_oe,
  input  logic [DATA_W-1:0] lcd_db_in
);

  logic slot_go, slot_sample, slot_done;

  lcdbus_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_rs      (cmd_rs),
    .cmd_rw      (cmd_rw),
    .cmd_data    (cmd_data),
    .nibble_mode (nibble_mode),
    .poll_en     (poll_en),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_status  (rsp_status),
    .rsp_busy    (rsp_busy),
    .rsp_addr    (rsp_addr),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .lcd_db_out  (lcd_db_out),
    .lcd_db_oe   (lcd_db_oe),
    .lcd_db_in   (lcd_db_in),
    .slot_sample (slot_sample),
    .slot_done   (slot_done),
    .slot_go     (slot_go)
  );

  lcdbus_strobe #(
    .SETUP_CYC  (SETUP_CYC),
    .E_HIGH_CYC (E_HIGH_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .CYCLE_CYC  (CYCLE_CYC)
  ) u_strobe (
    .clk         (clk),
    .rst         (rst),
    .slot_go     (slot_go),
    .lcd_e       (lcd_e),
    .slot_sample (slot_sample),
    .slot_done   (slot_done)
  );

endmodule

// File: rtl/lcdbus_drv_chk.sv
`timescale 1ns/1ps
module lcdbus_drv_chk #(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int E_HIGH_CYC = 23,
  parameter int HOLD_CYC   = 3,
  parameter int CYCLE_CYC  = 120
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              lcd_rs,
  input logic              lcd_rw,
  input logic              lcd_e,
  input logic [DATA_W-1:0] lcd_db_out,
  input logic              lcd_db_oe
);

  localparam int SLOT = lcdbus_pkg::slot_len(CYCLE_CYC, SETUP_CYC, E_HIGH_CYC, HOLD_CYC);
  localparam logic [15:0] SAT = 16'hFFFF;

  logic [DATA_W+2:0] bus;
  logic [DATA_W+2:0] bus_prev_q;
  logic [15:0] run_q, hi_q, fall_q, since_rise_q;
  logic        e_prev_q;

  assign bus = {lcd_rs, lcd_rw, lcd_db_oe, lcd_db_out};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_prev_q   <= bus;
      run_q        <= '0;
      hi_q         <= '0;
      fall_q       <= SAT;
      since_rise_q <= SAT;
      e_prev_q     <= 1'b0;
    end else begin
      bus_prev_q   <= bus;
      e_prev_q     <= lcd_e;
      run_q        <= (bus != bus_prev_q) ? 16'd0 : ((run_q == SAT) ? SAT : run_q + 16'd1);
      hi_q         <= lcd_e ? hi_q + 16'd1 : 16'd0;
      fall_q       <= (e_prev_q && !lcd_e) ? 16'd1 : ((fall_q == SAT) ? SAT : fall_q + 16'd1);
      since_rise_q <= (lcd_e && !e_prev_q) ? 16'd1 :
                      ((since_rise_q == SAT) ? SAT : since_rise_q + 16'd1);
    end
  end

  a_r1_enable_period: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_e) |-> (int'(since_rise_q) >= SLOT));

  a_r2_enable_width: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_e) |-> (int'(hi_q) == E_HIGH_CYC));

  a_r3_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_e) |-> ($stable(bus) && (int'(run_q) >= SETUP_CYC - 1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    ($fell(lcd_e) || (int'(fall_q) < HOLD_CYC)) |-> $stable(bus));

  a_r6_release_on_read: assert property (@(posedge clk) disable iff (rst)
    lcd_rw |-> !lcd_db_oe);

  a_r6_single_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !lcd_e);

endmodule

bind lcdbus_drv lcdbus_drv_chk #(
  .DATA_W     (DATA_W),
  .SETUP_CYC  (SETUP_CYC),
  .E_HIGH_CYC (E_HIGH_CYC),
  .HOLD_CYC   (HOLD_CYC),
  .CYCLE_CYC  (CYCLE_CYC)
) u_lcdbus_drv_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .lcd_rs     (lcd_rs),
  .lcd_rw     (lcd_rw),
  .lcd_e      (lcd_e),
  .lcd_db_out (lcd_db_out),
  .lcd_db_oe  (lcd_db_oe)
);

// File: tb/test_lcdbus_drv.sv
`timescale 1ns/1ps
module test_lcdbus_drv;

  localparam int S_C  = 2;
  localparam int H_C  = 4;
  localparam int HO_C = 2;
  localparam int CY_C = 10;
  localparam int SLOT = (CY_C > S_C + H_C + HO_C) ? CY_C : (S_C + H_C + HO_C);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       cmd_valid = 1'b0, cmd_rs = 1'b0, cmd_rw = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       nibble_mode = 1'b0, poll_en = 1'b0;
  logic       cmd_ready, rsp_valid, rsp_status, rsp_busy;
  logic [7:0] rsp_data;
  logic [6:0] rsp_addr;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [7:0] lcd_db_out, lcd_db_in;

  lcdbus_drv #(
    .DATA_W(8), .SETUP_CYC(S_C), .E_HIGH_CYC(H_C), .HOLD_CYC(HO_C), .CYCLE_CYC(CY_C)
  ) i_lcdbus_drv (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rs(cmd_rs), .cmd_rw(cmd_rw), .cmd_data(cmd_data),
    .nibble_mode(nibble_mode), .poll_en(poll_en),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status),
    .rsp_busy(rsp_busy), .rsp_addr(rsp_addr),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- controller model on the far side of the bus
  logic       tb_nib = 1'b0;
  logic       mdl_phase = 1'b0;
  int         busy_left = 0;
  logic [6:0] addr_val = 7'h00;
  logic [7:0] ram_val = 8'h00;
  logic [7:0] full_val;

  always_comb begin
    full_val = lcd_rs ? ram_val : {busy_left != 0, addr_val};
    if (!tb_nib)        lcd_db_in = full_val;
    else if (mdl_phase) lcd_db_in = {full_val[3:0], 4'h0};
    else                lcd_db_in = {full_val[7:4], 4'h0};
  end

  // ---------------- pulse log
  int         log_n = 0;
  logic       log_rs [16];
  logic       log_rw [16];
  logic       log_oe [16];
  logic [7:0] log_db [16];
  time        rise_t [16];
  time        fall_t [16];
  time        setup_t[16];
  time        last_chg = 0, last_fall = 0, prev_rise = 0;
  bit         have_rise = 0, have_fall = 0;
  int         per_viol = 0, hold_viol = 0;

  always @(lcd_rs or lcd_rw or lcd_db_out or lcd_db_oe) begin
    if (!rst && !lcd_e && have_fall && (($time - last_fall) < HO_C * 10)) hold_viol++;
    if (!rst && lcd_e) hold_viol++;
    last_chg = $time;
  end

  always @(posedge lcd_e) begin
    if (have_rise && (($time - prev_rise) < SLOT * 10)) per_viol++;
    prev_rise = $time;
    have_rise = 1;
    if (log_n < 16) begin
      rise_t[log_n]  = $time;
      setup_t[log_n] = $time - last_chg;
    end
  end

  always @(negedge lcd_e) begin
    last_fall = $time;
    have_fall = 1;
    if (log_n < 16) begin
      fall_t[log_n] = $time;
      log_rs[log_n] = lcd_rs;
      log_rw[log_n] = lcd_rw;
      log_oe[log_n] = lcd_db_oe;
      log_db[log_n] = lcd_db_out;
    end
    log_n++;
    if (lcd_rw) begin
      if (tb_nib && !mdl_phase) mdl_phase = 1'b1;
      else begin
        mdl_phase = 1'b0;
        if (!lcd_rs && busy_left > 0) busy_left--;
      end
    end
  end

  // ---------------- command task
  logic       got_rsp;
  logic [7:0] r_data;
  logic       r_status, r_busy;
  logic [6:0] r_addr;
  logic       ready_after;

  task automatic run_cmd(input logic rs, input logic rw, input logic [7:0] d,
                         input logic nib, input logic poll);
    bit fin;
    @(negedge clk);
    log_n = 0; tb_nib = nib; mdl_phase = 1'b0; got_rsp = 1'b0;
    cmd_rs = rs; cmd_rw = rw; cmd_data = d; nibble_mode = nib; poll_en = poll;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    nibble_mode = !nib;   // R9: must not affect the running command
    poll_en = !poll;
    ready_after = cmd_ready;
    fin = 0;
    while (!fin) begin
      if (rsp_valid) begin
        got_rsp = 1'b1; r_data = rsp_data; r_status = rsp_status;
        r_busy = rsp_busy; r_addr = rsp_addr;
      end
      if (cmd_ready) fin = 1;
      else @(negedge clk);
    end
  endtask

  task automatic chk_timing(input int idx);
    chk((fall_t[idx] - rise_t[idx]) == H_C * 10, "R2 enable width",
        fall_t[idx] - rise_t[idx], H_C * 10);
    chk(setup_t[idx] >= S_C * 10, "R3 setup", setup_t[idx], S_C * 10);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!lcd_e && !lcd_rs && lcd_rw && !lcd_db_oe && lcd_db_out == 8'h00,
        "R10 bus idle", {lcd_e, lcd_rs, lcd_rw, lcd_db_oe, lcd_db_out}, 12'h200);
    chk(cmd_ready && !rsp_valid, "R10 handshake", {cmd_ready, rsp_valid}, 2'b10);

    // R4 / R3 / R2 / R11: byte writes, every value
    for (int v = 0; v < 256; v++) begin
      run_cmd(v[0], 1'b0, 8'(v), 1'b0, 1'b0);
      chk(ready_after == 1'b0, "R11 ready low after accept", ready_after, 0);
      chk(log_n == 1, "R4 pulse count", log_n, 1);
      chk(log_db[0] == 8'(v) && log_rs[0] == v[0] && !log_rw[0] && log_oe[0],
          "R4 byte write", {log_rs[0], log_rw[0], log_oe[0], log_db[0]},
          {v[0], 2'b01, 8'(v)});
      chk_timing(0);
    end

    // R5 / R1 / R9: nibble writes, every value
    for (int v = 0; v < 256; v++) begin
      run_cmd(1'b1, 1'b0, 8'(v), 1'b1, 1'b0);
      chk(log_n == 2, "R5 R9 pulse count", log_n, 2);
      chk(log_db[0] == {v[7:4], 4'h0}, "R5 upper nibble first", log_db[0], {v[7:4], 4'h0});
      chk(log_db[1] == {v[3:0], 4'h0}, "R5 lower nibble second", log_db[1], {v[3:0], 4'h0});
      chk((rise_t[1] - rise_t[0]) == SLOT * 10, "R1 nibble pulse spacing",
          rise_t[1] - rise_t[0], SLOT * 10);
      chk_timing(1);
    end

    // R6 / R7: data reads in both modes, every value
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        ram_val = 8'(v);
        run_cmd(1'b1, 1'b1, 8'h00, m[0], 1'b0);
        chk(got_rsp && r_data == 8'(v), "R6 read data", r_data, v);
        chk(!r_status && !r_busy && r_addr == 7'h00, "R7 data read flags",
            {r_status, r_busy, r_addr}, 0);
        chk(log_n == m + 1 && log_rw[0] && !log_oe[0], "R6 released on read",
            {log_n[3:0], log_rw[0], log_oe[0]}, {4'(m + 1), 2'b10});
      end
    end

    // R7: status reads, busy and clear, both modes
    for (int m = 0; m < 2; m++) begin
      for (int b = 1; b >= 0; b--) begin
        addr_val = 7'(8'h35 + 8'(m * 17 + b * 9));
        busy_left = b;
        run_cmd(1'b0, 1'b1, 8'h00, m[0], 1'b0);
        chk(got_rsp && r_status && r_busy == b[0] && r_addr == addr_val,
            "R7 status decode", {r_status, r_busy, r_addr}, {1'b1, b[0], addr_val});
        chk(r_data == {b[0], addr_val}, "R7 status byte", r_data, {b[0], addr_val});
      end
    end

    // R8: polling after writes
    for (int m = 0; m < 2; m++) begin
      busy_left = 3;
      run_cmd(1'b1, 1'b0, 8'hA5, m[0], 1'b1);
      chk(log_n == (m + 1) * 5, "R8 poll until clear", log_n, (m + 1) * 5);
      chk(log_n > m + 1 && !log_rs[m + 1] && log_rw[m + 1] && !log_oe[m + 1],
          "R8 poll is status read", {log_rs[m + 1], log_rw[m + 1], log_oe[m + 1]}, 3'b010);
      chk(busy_left == 0, "R8 model drained", busy_left, 0);
    end
    busy_left = 3;
    run_cmd(1'b1, 1'b0, 8'h3C, 1'b0, 1'b0);
    chk(log_n == 1, "R8 no poll when disabled", log_n, 1);
    ram_val = 8'h77;
    run_cmd(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
    chk(log_n == 1 && r_data == 8'h77, "R8 no poll after read", log_n, 1);
    busy_left = 0;

    chk(per_viol == 0, "R1 period violations", per_viol, 0);
    chk(hold_viol == 0, "R3 hold violations", hold_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule